// File: doc/BRIEF.md
# Transform Pass Address Sequencer

This block drives the memory side of a 256-point number-theoretic transform over a 12-bit prime field. On each start command it walks through one radix-2 layer of the transform. In every cycle of that layer it presents one butterfly's pair of coefficient addresses together with the index of the twiddle factor that butterfly needs and the twiddle table to read it from. It then raises a one-cycle completion pulse and goes quiet. Between passes the surrounding controller can drain its arithmetic pipeline and exchange its ping-pong buffer pointers.

The forward direction follows the decimation-in-time (Cooley-Tukey) loop nest, with spans that halve from 128 down to 2 and a twiddle index that climbs once per group. The inverse direction follows the decimation-in-frequency (Gentleman-Sande) loop nest, with spans that double from 2 up to 128 and a twiddle index that falls once per group. The controller chooses the direction and the pass number when it issues start, and the sequencer captures both at that moment.

The control is a three-state machine. `ST_IDLE` waits for a legal start and moves to `ST_RUN` when it gets one. `ST_RUN` emits one butterfly per cycle and moves to `ST_DONE` after the last butterfly of the layer. `ST_DONE` raises the completion pulse for one cycle and returns unconditionally to `ST_IDLE`. A loop-counter submodule holds the group base, the offset within the group, the twiddle index and the butterfly count. A decoder submodule turns the direction and pass number into a span and a first twiddle index.

Top module: `twaddr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `valid` and `pass_done` are both 0.
- R2: A start accepted in `ST_IDLE` presents the first butterfly in the cycle after the capturing clock edge. `valid` then stays high for exactly 128 consecutive cycles.
- R3: A forward pass `p` (`dir_inv`=0) uses span s = 128 >> p. It emits the pair (j, j+s) with the group base rising through 0, 2s, 4s, and so on up to 256, and with j rising through base..base+s-1 inside each group.
- R4: In a forward pass, `tw_idx` equals 128/s for the first group and rises by 1 at each new group. `tw_table` is 0, which selects the forward table.
- R5: An inverse pass `p` (`dir_inv`=1) uses span s = 2 << p, with the same group and in-group address order as R3.
- R6: In an inverse pass, `tw_idx` equals 256/s − 1 for the first group and falls by 1 at each new group. `tw_table` is 1, which selects the inverse table.
- R7: `pass_done` is high for exactly one cycle, the cycle right after the last valid butterfly. `valid` is 0 in that cycle.
- R8: While a pass is running or finishing (`ST_RUN`, `ST_DONE`), `start`, `dir_inv` and `pass_idx` have no effect. The address stream continues unchanged, and no extra pass follows.
- R9: A start with `pass_idx` of 7 or more is ignored. The block stays idle and `valid` stays 0.
- R10: A start presented in the cycle right after `pass_done` is accepted, so passes can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one pass; sampled only in ST_IDLE |
| dir_inv | input | 1 | 0 = forward transform, 1 = inverse transform |
| pass_idx | input | 3 | Pass number, 0..6 |
| addr_a | output | 8 | Lower coefficient address j of the butterfly |
| addr_b | output | 8 | Upper coefficient address j+s |
| tw_idx | output | 7 | Twiddle index within the selected table |
| tw_table | output | 2 | Twiddle table: 0 forward, 1 inverse, 2 fourth-root constants |
| valid | output | 1 | Addresses and twiddle are meaningful this cycle |
| pass_done | output | 1 | One-cycle pulse after the last butterfly of a pass |

## Verification
A corrupted offset or group base shows at once as a wrong address pair, in the same cycle that holds the bad value. A twiddle counter that steps at the wrong time shows as a wrong index at the very next group boundary. A butterfly counter or state register that goes wrong moves the `pass_done` pulse off by at least one cycle, or lengthens or shortens the run of `valid`. The bench compares every butterfly of every pass in both directions against a software loop nest, so any such deviation is reported in the cycle it first reaches the ports.

// File: rtl/twaddr_pkg.sv
package twaddr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TBL_FWD   = 2'd0,
        TBL_INV   = 2'd1,
        TBL_QROOT = 2'd2
    } tw_table_e;

endpackage

// File: rtl/twaddr_span_decode.sv
module twaddr_span_decode #(
    parameter int LOG_N = 8,
    parameter int PW    = 3,
    parameter int LW    = 3,
    parameter int TW    = 7
) (
    input  logic          dir_inv,
    input  logic [PW-1:0] pass_idx,
    output logic          legal,
    output logic [LW-1:0] span_lg,
    output logic [TW-1:0] tw_first
);
    localparam int LAYERS = LOG_N - 1;

    always_comb begin
        legal = int'(pass_idx) < LAYERS;
        if (dir_inv)
            span_lg = LW'(int'(pass_idx) + 1);
        else
            span_lg = LW'(LAYERS - int'(pass_idx));
        if (dir_inv)
            tw_first = TW'((1 << (LOG_N - int'(span_lg))) - 1);
        else
            tw_first = TW'(1 << (LAYERS - int'(span_lg)));
    end

endmodule

// File: rtl/twaddr_loop_ctr.sv
module twaddr_loop_ctr #(
    parameter int LOG_N = 8,
    parameter int LW    = 3,
    parameter int TW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [LW-1:0]    span_lg,
    input  logic [TW-1:0]    tw_first,
    input  logic             tw_down,
    output logic [LOG_N-1:0] addr_a,
    output logic [LOG_N-1:0] addr_b,
    output logic [TW-1:0]    tw_idx,
    output logic             last
);
    localparam int AW = LOG_N;
    localparam int CW = LOG_N - 1;

    logic [AW-1:0] off_q, base_q;
    logic [TW-1:0] tw_q;
    logic [CW-1:0] cnt_q;
    logic [AW:0]   span_w;
    logic [AW:0]   base_nx;
    logic          group_end;

    always_comb begin
        span_w    = (AW+1)'(1) << span_lg;
        group_end = ({1'b0, off_q} == span_w - (AW+1)'(1));
        base_nx   = {1'b0, base_q} + (span_w << 1);
        last      = (cnt_q == {CW{1'b1}});
        addr_a    = base_q | off_q;
        addr_b    = addr_a + span_w[AW-1:0];
        tw_idx    = tw_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            base_q <= '0;
            tw_q   <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            off_q  <= '0;
            base_q <= '0;
            tw_q   <= tw_first;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + CW'(1);
            if (group_end) begin
                off_q  <= '0;
                base_q <= base_nx[AW-1:0];
                tw_q   <= tw_down ? tw_q - TW'(1) : tw_q + TW'(1);
            end else begin
                off_q <= off_q + AW'(1);
            end
        end
    end

    // R4 / R6: the twiddle index moves only at a group boundary
    assert_tw_hold_in_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !group_end && !load) |=> (tw_idx == $past(tw_idx)));

    // R3 / R5: within a group the lower address climbs by exactly one
    assert_addr_step_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !group_end && !load) |=> (addr_a == $past(addr_a) + AW'(1)));

endmodule

// File: rtl/twaddr_seq.sv
module twaddr_seq #(
    parameter int LOG_N = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              dir_inv,
    input  logic [$clog2(LOG_N-1)-1:0]        pass_idx,
    output logic [LOG_N-1:0]                  addr_a,
    output logic [LOG_N-1:0]                  addr_b,
    output logic [LOG_N-2:0]                  tw_idx,
    output logic [1:0]                        tw_table,
    output logic                              valid,
    output logic                              pass_done
);
    import twaddr_pkg::*;

    localparam int LAYERS = LOG_N - 1;
    localparam int PW     = $clog2(LAYERS);
    localparam int LW     = $clog2(LOG_N);
    localparam int TW     = LOG_N - 1;
    localparam int HALF_N = 1 << (LOG_N - 1);

    seq_state_e    state_q, state_nx;
    logic          dir_q;
    logic [LW-1:0] span_q;
    logic          legal;
    logic [LW-1:0] span_dec;
    logic [TW-1:0] tw_first;
    logic          accept;
    logic          last;

    twaddr_span_decode #(.LOG_N(LOG_N), .PW(PW), .LW(LW), .TW(TW)) u_dec (
        .dir_inv  (dir_inv),
        .pass_idx (pass_idx),
        .legal    (legal),
        .span_lg  (span_dec),
        .tw_first (tw_first)
    );

    twaddr_loop_ctr #(.LOG_N(LOG_N), .LW(LW), .TW(TW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  (state_q == ST_RUN),
        .span_lg  (accept ? span_dec : span_q),
        .tw_first (tw_first),
        .tw_down  (dir_q),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .tw_idx   (tw_idx),
        .last     (last)
    );

    assign accept = (state_q == ST_IDLE) && start && legal;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_nx = ST_RUN;
            ST_RUN:  if (last)   state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            span_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                dir_q  <= dir_inv;
                span_q <= span_dec;
            end
        end
    end

    always_comb begin
        valid     = (state_q == ST_RUN);
        pass_done = (state_q == ST_DONE);
        tw_table  = dir_q ? 2'(TBL_INV) : 2'(TBL_FWD);
    end

    // checker counter: valid cycles since the last accepted start
    logic [LOG_N:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_cnt <= '0;
        else if (accept) chk_cnt <= '0;
        else if (valid)  chk_cnt <= chk_cnt + (LOG_N+1)'(1);
    end

    assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (chk_cnt == (LOG_N+1)'(HALF_N)));

    assert_valid_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(start));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    assert_done_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> ($past(valid) && !valid));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start) |=> (valid || pass_done));

    assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (addr_b > addr_a));

endmodule

// File: tb/twaddr_seq_test.sv
module twaddr_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir_inv = 1'b0;
    logic [2:0] pass_idx = 3'd0;
    logic [7:0] addr_a, addr_b;
    logic [6:0] tw_idx;
    logic [1:0] tw_table;
    logic       valid, pass_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    twaddr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_inv(dir_inv),
        .pass_idx(pass_idx), .addr_a(addr_a), .addr_b(addr_b),
        .tw_idx(tw_idx), .tw_table(tw_table), .valid(valid),
        .pass_done(pass_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge with the block idle. Optionally pokes start with
    // different settings at butterfly poke_at and in the done cycle (R8).
    task automatic run_pass(input bit inv, input int p, input int poke_at);
        int s, tw, n;
        string rq;
        s  = inv ? (2 << p) : (128 >> p);
        tw = inv ? (256 / s - 1) : (128 / s);
        rq = inv ? "R5" : "R3";
        dir_inv  = inv;
        pass_idx = 3'(p);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int base = 0; base < 256; base += 2 * s) begin
            for (int j = base; j < base + s; j++) begin
                if (n == poke_at) begin
                    start = 1'b1; dir_inv = ~inv; pass_idx = 3'((p + 3) % 7);
                end else begin
                    start = 1'b0;
                end
                check(valid === 1'b1, "R2", "valid during pass", int'(valid), 1);
                check(addr_a === 8'(j) && addr_b === 8'(j + s), rq, "pair lower",
                      int'(addr_a), j);
                check(tw_idx === 7'(tw), inv ? "R6" : "R4", "twiddle index",
                      int'(tw_idx), tw);
                check(tw_table === (inv ? 2'd1 : 2'd0), inv ? "R6" : "R4",
                      "table select", int'(tw_table), inv ? 1 : 0);
                if (poke_at >= 0 && n > poke_at)
                    check(addr_a === 8'(j), "R8", "busy start no effect", int'(addr_a), j);
                n++;
                @(negedge clk);
            end
            tw = inv ? tw - 1 : tw + 1;
        end
        start = 1'b0;
        check(pass_done === 1'b1 && valid === 1'b0, "R7", "done pulse", int'(pass_done), 1);
        if (poke_at >= 0) begin
            start = 1'b1; pass_idx = 3'd0;
        end
        @(negedge clk);
        start = 1'b0;
        check(pass_done === 1'b0, "R7", "done lasts one cycle", int'(pass_done), 0);
        check(valid === 1'b0, poke_at >= 0 ? "R8" : "R7", "idle after done", int'(valid), 0);
    endtask

    task automatic test_reset();
        check(valid === 1'b0, "R1", "valid in reset", int'(valid), 0);
        check(pass_done === 1'b0, "R1", "done in reset", int'(pass_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid === 1'b0 && pass_done === 1'b0, "R1", "after reset", int'(valid), 0);
    endtask

    task automatic test_forward();
        for (int p = 0; p < 7; p++) run_pass(1'b0, p, -1);
    endtask

    task automatic test_inverse();
        for (int p = 0; p < 7; p++) run_pass(1'b1, p, -1);
    endtask

    // R10: passes issued back to back, start in the cycle after pass_done
    task automatic test_back_to_back();
        run_pass(1'b0, 6, -1);
        run_pass(1'b1, 0, -1);
        check(1'b1, "R10", "back-to-back passes completed", 1, 1);
    endtask

    task automatic test_busy();
        run_pass(1'b0, 3, 40);
        run_pass(1'b1, 5, 3);
    endtask

    task automatic test_illegal_pass();
        dir_inv = 1'b0; pass_idx = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(valid === 1'b0 && pass_done === 1'b0, "R9", "illegal pass ignored",
                  int'(valid), 0);
            @(negedge clk);
        end
        dir_inv = 1'b1; pass_idx = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid === 1'b0, "R9", "illegal inverse pass ignored", int'(valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_forward();
        test_inverse();
        test_back_to_back();
        test_busy();
        test_illegal_pass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule